// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block runs a four-phase strobe/acknowledge interlock for an 8-bit parallel port. The port works in one direction at a time, chosen by a mode input. In receive mode an external source places a byte on the pins and pulls the active-low strobe `stb_n_i` low. The block captures the byte and drops `ack_o` to show that the byte is held. It raises `ack_o` again only once the strobe has returned high and the CPU has read the byte. In transmit mode a CPU write loads a byte and drives it onto the pins. One cycle later, and only if the receiver's `ack_i` is high, the block pulls `stb_n_o` low. It releases the strobe once the receiver drops `ack_i`, and it finishes when `ack_i` rises again.

Both pin-side control inputs pass through two-flop synchronisers before either state machine sees them. The receive side has three states: RX_READY, RX_HELD and RX_DRAIN. RX_READY moves to RX_HELD when the synchronised strobe is low and the buffer is empty; this move captures the byte. RX_HELD moves to RX_DRAIN when the strobe returns high while the byte is still unread, and to RX_READY when the strobe returns high and the buffer is already empty. RX_DRAIN moves to RX_READY when the CPU read empties the buffer. The transmit side has four states: TX_IDLE, TX_SETUP, TX_STROBE and TX_RELEASE. TX_IDLE moves to TX_SETUP on a CPU write. TX_SETUP moves to TX_STROBE when the synchronised `ack_i` is high. TX_STROBE moves to TX_RELEASE when it is low. TX_RELEASE moves to TX_IDLE when it is high again. When a side's mode is not selected, that side's state machine is forced to its idle state.

Top module: `hs_parport`

## Requirements
- R1: While reset is asserted and right after it, `ack_o`=1, `stb_n_o`=1, `full_o`=0, `busy_o`=0 and `pdata_o`=0.
- R2: In receive mode (`mode_tx`=0) with the buffer empty, the byte on `pdata_i` while the strobe is seen low is captured into `cpu_rdata`, `full_o` becomes 1 and `ack_o` falls.
- R3: In receive mode `ack_o` stays low while `stb_n_i` is low. It rises only after the synchronised strobe has been seen high.
- R4: While `full_o`=1, `ack_o` stays low even after the strobe is released, until a `cpu_rd` pulse. The cycle after that pulse `full_o` is 0, and `ack_o` is high once the strobe is high.
- R5: In transmit mode (`mode_tx`=1) a `cpu_wr` in TX_IDLE loads `cpu_wdata` onto `pdata_o` and sets `busy_o` at the next edge, while `stb_n_o` is still 1. The byte is on `pdata_o` at least one cycle before `stb_n_o` falls.
- R6: `stb_n_o` stays low until the synchronised `ack_i` is seen low, and rises afterwards.
- R7: `busy_o` stays 1 after the strobe release until the synchronised `ack_i` is seen high again. Only then may a new transfer start.
- R8: A `cpu_wr` while `busy_o`=1 is ignored: `pdata_o` and the transfer in progress are unchanged.
- R9: `stb_n_o` falls only while the synchronised `ack_i` is high. A receiver that holds `ack_i` low keeps the block in TX_SETUP.
- R10: `pdata_oe` equals `mode_tx`. In transmit mode `ack_o`=1 and `stb_n_i` is ignored (`full_o` stays 0). In receive mode `stb_n_o`=1 and `cpu_wr` is ignored (`busy_o` stays 0).
- R11: Receive latency: if `stb_n_i` falls between edges, `ack_o` is still high after the second following rising edge and low after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| pdata_i | input | 8 | Byte from the pins (receive) |
| stb_n_i | input | 1 | Active-low strobe from the external source |
| ack_o | output | 1 | Acknowledge to the external source |
| pdata_o | output | 8 | Byte driven onto the pins (transmit) |
| pdata_oe | output | 1 | Output enable for the data pins |
| stb_n_o | output | 1 | Active-low strobe to the receiver |
| ack_i | input | 1 | Acknowledge from the receiver |
| cpu_wr | input | 1 | CPU load strobe for a byte to send |
| cpu_wdata | input | 8 | Byte to send |
| cpu_rd | input | 1 | CPU read strobe; empties the receive buffer |
| cpu_rdata | output | 8 | Last captured byte |
| full_o | output | 1 | Receive buffer holds an unread byte |
| busy_o | output | 1 | Transmit transfer in progress |

## Verification
The assertions assume that both pin-side partners keep to the interlock. The source does not pull the strobe low again while `ack_o` is low, and it holds data until `ack_o` falls. The receiver changes `ack_i` only in answer to the strobe. They also assume `mode_tx` changes only while both sides are idle. The bench's source and receiver models wait for each expected edge before moving, and they insert random delays only between those edges. The mode is switched only between transfers.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        RX_READY = 2'd0,
        RX_HELD  = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_SETUP   = 2'd1,
        TX_STROBE  = 2'd2,
        TX_RELEASE = 2'd3
    } tx_state_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hs_rx_fsm.sv
module hs_rx_fsm
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         stb_s,
    input  logic [W-1:0] data_in,
    input  logic         rd,
    output logic         ack,
    output logic         full,
    output logic [W-1:0] rdata
);

    rx_state_t state_q, state_d;
    logic      capture;
    logic      full_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        if (!en) begin
            state_d = RX_READY;
        end else begin
            unique case (state_q)
                RX_READY: begin
                    if (!stb_s && !full_q) begin
                        capture = 1'b1;
                        state_d = RX_HELD;
                    end
                end
                RX_HELD: begin
                    if (stb_s) state_d = full_q ? RX_DRAIN : RX_READY;
                end
                RX_DRAIN: begin
                    if (!full_q) state_d = RX_READY;
                end
                default: state_d = RX_READY;
            endcase
        end
    end

    // buffer and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            rdata  <= '0;
        end else begin
            if (capture) begin
                full_q <= 1'b1;
                rdata  <= data_in;
            end else if (rd) begin
                full_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        ack  = (state_q == RX_READY) && !full_q;
        full = full_q;
    end

endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ack_s,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         stb_n,
    output logic         busy,
    output logic [W-1:0] data_out
);

    tx_state_t state_q, state_d;
    logic      load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        if (!en) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (wr) begin
                        load    = 1'b1;
                        state_d = TX_SETUP;
                    end
                end
                TX_SETUP:   if (ack_s)  state_d = TX_STROBE;
                TX_STROBE:  if (!ack_s) state_d = TX_RELEASE;
                TX_RELEASE: if (ack_s)  state_d = TX_IDLE;
                default:    state_d = TX_IDLE;
            endcase
        end
    end

    // data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_out <= '0;
        else if (load) data_out <= wdata;
    end

    // outputs
    always_comb begin
        stb_n = (state_q != TX_STROBE);
        busy  = (state_q != TX_IDLE);
    end

endmodule

// File: rtl/hs_parport.sv
module hs_parport #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_tx,
    input  logic [W-1:0] pdata_i,
    input  logic         stb_n_i,
    output logic         ack_o,
    output logic [W-1:0] pdata_o,
    output logic         pdata_oe,
    output logic         stb_n_o,
    input  logic         ack_i,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_wdata,
    input  logic         cpu_rd,
    output logic [W-1:0] cpu_rdata,
    output logic         full_o,
    output logic         busy_o
);

    localparam int NCTL = 2;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic            stb_s, ack_s;
    logic            rx_ack;
    logic            tx_stb_n;

    assign ctl_raw = {ack_i, stb_n_i};

    hs_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL({NCTL{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    assign stb_s = ctl_s[0];
    assign ack_s = ctl_s[1];

    hs_rx_fsm #(.W(W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (!mode_tx),
        .stb_s   (stb_s),
        .data_in (pdata_i),
        .rd      (cpu_rd),
        .ack     (rx_ack),
        .full    (full_o),
        .rdata   (cpu_rdata)
    );

    hs_tx_fsm #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mode_tx),
        .ack_s    (ack_s),
        .wr       (cpu_wr),
        .wdata    (cpu_wdata),
        .stb_n    (tx_stb_n),
        .busy     (busy_o),
        .data_out (pdata_o)
    );

    assign ack_o    = mode_tx ? 1'b1 : rx_ack;
    assign stb_n_o  = tx_stb_n;
    assign pdata_oe = mode_tx;

endmodule

// File: rtl/hs_parport_chk.sv
module hs_parport_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_tx,
    input logic         ack_o,
    input logic         stb_n_o,
    input logic [W-1:0] pdata_o,
    input logic         full_o,
    input logic         busy_o,
    input logic         cpu_rd,
    input logic         stb_s,
    input logic         ack_s
);

    // R3: acknowledge returns only after the strobe was seen released
    assert_ack_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && $rose(ack_o)) |-> $past(stb_s));

    // R4: an unread byte keeps the buffer full
    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !cpu_rd) |=> full_o);

    // R2: acknowledge falls only together with a captured byte
    assert_ack_fall_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && $fell(ack_o)) |-> full_o);

    // R5: data steady and busy when the strobe falls
    assert_data_before_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && $fell(stb_n_o)) |-> ($stable(pdata_o) && busy_o));

    // R6: strobe released only after the receiver acknowledged
    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && $past(mode_tx) && $rose(stb_n_o)) |-> !$past(ack_s));

    // R7: transfer ends only after acknowledge came back high
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && $past(mode_tx) && $fell(busy_o)) |-> $past(ack_s));

    // R9: strobe falls only while the receiver is ready
    assert_strobe_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && $fell(stb_n_o)) |-> $past(ack_s));

endmodule

bind hs_parport hs_parport_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_tx (mode_tx),
    .ack_o   (ack_o),
    .stb_n_o (stb_n_o),
    .pdata_o (pdata_o),
    .full_o  (full_o),
    .busy_o  (busy_o),
    .cpu_rd  (cpu_rd),
    .stb_s   (stb_s),
    .ack_s   (ack_s)
);

// File: tb/test_hs_parport.sv
module test_hs_parport;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_tx = 1'b0;
    logic [W-1:0] pdata_i = '0;
    logic         stb_n_i = 1'b1;
    logic         ack_o;
    logic [W-1:0] pdata_o;
    logic         pdata_oe;
    logic         stb_n_o;
    logic         ack_i = 1'b1;
    logic         cpu_wr = 1'b0;
    logic [W-1:0] cpu_wdata = '0;
    logic         cpu_rd = 1'b0;
    logic [W-1:0] cpu_rdata;
    logic         full_o;
    logic         busy_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_parport #(.W(W)) i_hs_parport (
        .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .pdata_i(pdata_i),
        .stb_n_i(stb_n_i), .ack_o(ack_o), .pdata_o(pdata_o), .pdata_oe(pdata_oe),
        .stb_n_o(stb_n_o), .ack_i(ack_i), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .full_o(full_o), .busy_o(busy_o)
    );

    function automatic logic [W-1:0] expect_byte(input logic [W-1:0] sent);
        return sent;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_edge();
        @(negedge clk);
    endtask

    // wait until ack_o equals val, at most lim cycles; returns cycles waited
    task automatic wait_ack(input logic val, input int lim, output int n);
        n = 0;
        while (ack_o !== val && n < lim) begin tick(); n++; end
    endtask

    task automatic wait_stb(input logic val, input int lim, output int n);
        n = 0;
        while (stb_n_o !== val && n < lim) begin tick(); n++; end
    endtask

    // receive one byte; early_rd reads before the strobe is released
    task automatic rx_xfer(input logic [W-1:0] b, input bit early_rd, input int hold);
        int n;
        drive_edge();
        pdata_i = b;
        stb_n_i = 1'b0;
        tick();
        wait_ack(1'b0, 10, n);
        check(ack_o === 1'b0, "R2 ack fall", ack_o, 0);
        check(cpu_rdata === expect_byte(b) && full_o === 1'b1, "R2 capture", cpu_rdata, b);
        for (int i = 0; i < hold; i++) tick();
        check(ack_o === 1'b0, "R3 ack low while strobe low", ack_o, 0);
        if (early_rd) begin
            drive_edge(); cpu_rd = 1'b1;
            drive_edge(); cpu_rd = 1'b0;
            #1;
            check(full_o === 1'b0, "R4 full cleared", full_o, 0);
            check(ack_o === 1'b0, "R3 still low before release", ack_o, 0);
            drive_edge(); stb_n_i = 1'b1; pdata_i = $urandom;
            tick();
            wait_ack(1'b1, 10, n);
            check(ack_o === 1'b1, "R3 ack rises after release", ack_o, 1);
        end else begin
            drive_edge(); stb_n_i = 1'b1; pdata_i = $urandom;
            for (int i = 0; i < 6; i++) tick();
            check(ack_o === 1'b0 && full_o === 1'b1, "R4 blocked until read", {full_o, ack_o}, 2);
            drive_edge(); cpu_rd = 1'b1;
            drive_edge(); cpu_rd = 1'b0;
            #1;
            check(full_o === 1'b0, "R4 full cleared", full_o, 0);
            wait_ack(1'b1, 4, n);
            check(ack_o === 1'b1, "R4 ack back after read", ack_o, 1);
        end
    endtask

    // send one byte with a receiver model using random delays
    task automatic tx_xfer(input logic [W-1:0] b, input int d1, input int d2, input bit poke);
        int n;
        drive_edge(); cpu_wr = 1'b1; cpu_wdata = b;
        drive_edge(); cpu_wr = 1'b0; cpu_wdata = ~b;
        #1;
        check(busy_o === 1'b1 && stb_n_o === 1'b1, "R5 busy before strobe", {busy_o, stb_n_o}, 3);
        check(pdata_o === b, "R5 data driven", pdata_o, b);
        wait_stb(1'b0, 10, n);
        check(stb_n_o === 1'b0, "R5 strobe falls", stb_n_o, 0);
        if (poke) begin
            drive_edge(); cpu_wr = 1'b1; cpu_wdata = ~b;
            drive_edge(); cpu_wr = 1'b0;
            #1;
            check(pdata_o === b && busy_o === 1'b1, "R8 write while busy ignored", pdata_o, b);
        end
        for (int i = 0; i < d1; i++) tick();
        check(stb_n_o === 1'b0, "R6 strobe held until ack low", stb_n_o, 0);
        drive_edge(); ack_i = 1'b0;
        tick();
        wait_stb(1'b1, 10, n);
        check(stb_n_o === 1'b1, "R6 strobe released", stb_n_o, 1);
        for (int i = 0; i < d2; i++) tick();
        check(busy_o === 1'b1, "R7 busy while ack low", busy_o, 1);
        drive_edge(); ack_i = 1'b1;
        n = 0;
        tick();
        while (busy_o !== 1'b0 && n < 10) begin tick(); n++; end
        check(busy_o === 1'b0 && pdata_o === b, "R7 transfer done", busy_o, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        #3;
        check(ack_o === 1'b1 && stb_n_o === 1'b1 && full_o === 1'b0 && busy_o === 1'b0,
              "R1 reset outputs", {ack_o, stb_n_o, full_o, busy_o}, 4'b1100);
        repeat (3) tick();
        drive_edge(); rst_n = 1'b1;
        tick();
        check(ack_o === 1'b1 && stb_n_o === 1'b1 && full_o === 1'b0 && busy_o === 1'b0 && pdata_o === 0,
              "R1 after reset", {ack_o, stb_n_o, full_o, busy_o}, 4'b1100);
        check(pdata_oe === 1'b0, "R10 oe in receive mode", pdata_oe, 0);

        // R11 exact latency
        drive_edge(); pdata_i = 8'hA5; stb_n_i = 1'b0;
        tick(); tick();
        check(ack_o === 1'b1, "R11 ack high after 2 edges", ack_o, 1);
        tick();
        check(ack_o === 1'b0 && cpu_rdata === 8'hA5, "R11 ack low after 3 edges", ack_o, 0);
        drive_edge(); stb_n_i = 1'b1;
        drive_edge(); cpu_rd = 1'b1;
        drive_edge(); cpu_rd = 1'b0;
        repeat (4) tick();
        check(ack_o === 1'b1 && full_o === 1'b0, "R4 ack back", ack_o, 1);

        // directed receive corners
        rx_xfer(8'h00, 1'b0, 0);
        rx_xfer(8'hFF, 1'b1, 3);

        // R10: input mode ignores cpu writes
        drive_edge(); cpu_wr = 1'b1; cpu_wdata = 8'h3C;
        drive_edge(); cpu_wr = 1'b0;
        repeat (4) tick();
        check(busy_o === 1'b0 && stb_n_o === 1'b1 && pdata_o === 8'h00, "R10 write ignored in receive", busy_o, 0);

        // random receive
        for (int k = 0; k < 20; k++) rx_xfer(W'($urandom), 1'($urandom), int'($urandom_range(0, 4)));

        // switch to transmit mode
        drive_edge(); mode_tx = 1'b1;
        tick();
        check(pdata_oe === 1'b1 && ack_o === 1'b1, "R10 transmit mode outputs", {pdata_oe, ack_o}, 3);
        drive_edge(); stb_n_i = 1'b0; pdata_i = 8'h77;
        repeat (6) tick();
        check(full_o === 1'b0 && ack_o === 1'b1, "R10 strobe ignored in transmit", full_o, 0);
        drive_edge(); stb_n_i = 1'b1;
        repeat (3) tick();

        // R9: receiver not ready
        drive_edge(); ack_i = 1'b0;
        drive_edge(); cpu_wr = 1'b1; cpu_wdata = 8'h5A;
        drive_edge(); cpu_wr = 1'b0;
        repeat (8) tick();
        check(stb_n_o === 1'b1 && busy_o === 1'b1, "R9 strobe waits for ready", stb_n_o, 1);
        drive_edge(); ack_i = 1'b1;
        tick();
        wait_stb(1'b0, 6, n);
        check(stb_n_o === 1'b0 && pdata_o === 8'h5A, "R9 strobe after ready", stb_n_o, 0);
        drive_edge(); ack_i = 1'b0;
        tick(); wait_stb(1'b1, 6, n);
        drive_edge(); ack_i = 1'b1;
        repeat (5) tick();
        check(busy_o === 1'b0, "R7 idle after R9 case", busy_o, 0);

        // directed and random transmit
        tx_xfer(8'h81, 0, 0, 1'b1);
        for (int k = 0; k < 20; k++)
            tx_xfer(W'($urandom), int'($urandom_range(0, 5)), int'($urandom_range(0, 5)), 1'($urandom));

        drive_edge(); mode_tx = 1'b0;
        repeat (2) tick();
        check(pdata_oe === 1'b0 && stb_n_o === 1'b1, "R10 back to receive", pdata_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule